// File: doc/BRIEF.md
# Multi-Bank OUT Endpoint Receive Controller

This block holds received data for one device-side OUT endpoint in one or two packet banks. The USB side presents each host OUT packet as a stream of byte strobes closed by an end-of-packet strobe. If a bank is free, the bytes land in it in round-robin order and the packet is acknowledged. If every bank is still held by the CPU, or the endpoint is not enabled, the packet is refused with a NAK indication and its bytes are dropped.

The CPU sees one bank at a time, called the current bank. Two flags describe it: a received flag, which can raise the interrupt, and a bank-owned flag, which says the bank holds a packet for the CPU. The two are cleared separately. Acknowledging the received flag only silences the interrupt. Releasing the bank frees its storage, moves the CPU view to the next bank, and reloads both flags from that bank's state. The CPU drains the bytes through a fall-through read port that also shows the byte count of the current bank.

Top module: `ep_out_ctrl`

## Requirements
- R1: After reset the received flag, bank-owned flag, interrupt, handshake strobe and byte count are all 0, and the current bank index is 0.
- R2: While `cfg_en` is low at the first beat of a packet, the packet is refused: `usb_hs_valid` and `usb_hs_nak` are both 1 in the cycle after the end strobe, and no flag or count changes.
- R3: An accepted packet gives `usb_hs_valid`=1 with `usb_hs_nak`=0 in the cycle after its end strobe. If it lands in the current bank, both flags read 1 from that same cycle and the byte count equals its length.
- R4: `irq` is 1 exactly when the received flag is 1 and `cpu_rx_ie` is 1.
- R5: A pulse on `cpu_ack_rx` clears the received flag in the next cycle. The bank-owned flag, byte count and stored bytes are unchanged.
- R6: A pulse on `cpu_release` while the bank-owned flag is 1 frees the current bank and clears its count. The current bank index then advances by one, wrapping to 0 after the last bank. From the next cycle both flags equal 1 if the newly current bank holds a packet, and 0 if it does not.
- R7: Accepted packets fill banks in round-robin order. A packet that lands in a bank other than the current one leaves both flags unchanged.
- R8: When every bank holds a packet, a new packet is refused with a NAK. Its bytes overwrite no stored data.
- R9: Bytes beyond `DEPTH` in one packet are dropped. The stored count saturates at `DEPTH`, and the packet is still acknowledged.
- R10: `cpu_rd_data` shows the byte at the current read offset of the current bank, starting at offset 0, and `cpu_rd_en` advances the offset. The output is 0 once the offset reaches the count, and also while the bank-owned flag is 0.
- R11: A pulse on `cpu_release` while the bank-owned flag is 0 changes nothing.
- R12: A zero-length packet (an end strobe with no byte) is acknowledged and owns a bank with a count of 0.
- R13: Acceptance is decided at a packet's first beat. A packet refused at its first beat stays refused, even if a bank is freed before its end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Endpoint enabled |
| usb_byte_vld | input | 1 | Received byte strobe |
| usb_byte | input | 8 | Received byte |
| usb_pkt_end | input | 1 | End of packet strobe (may coincide with the last byte) |
| usb_hs_valid | output | 1 | Handshake decision valid, one cycle after end strobe |
| usb_hs_nak | output | 1 | 1 = packet refused, 0 = packet acknowledged |
| cpu_rx_ie | input | 1 | Interrupt enable for the received flag |
| cpu_ack_rx | input | 1 | Clear pulse for the received flag |
| cpu_release | input | 1 | Release pulse for the current bank |
| cpu_rd_en | input | 1 | Advance the read offset |
| cpu_rd_data | output | 8 | Byte at the read offset of the current bank |
| cpu_byte_cnt | output | $clog2(DEPTH+1) | Byte count of the current bank |
| cpu_rx_flag | output | 1 | Received flag |
| cpu_bank_flag | output | 1 | Current bank holds a packet owned by the CPU |
| cpu_bank_sel | output | max(1,$clog2(NUM_BANKS)) | Index of the current bank |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with two banks of four bytes. This lets a sweep of packet lengths from zero to two bytes past the depth reach the empty packet, the exact fit and the overflow cases, and it makes the current bank alternate on every pass. With two banks, a second packet can land behind the current one, a third meets a fully held endpoint, and a release can fall in the middle of a refused packet. The bench tracks expected bank contents, flags and indices in its own small model, and computes each byte from the packet number and the byte position.

// File: rtl/ep_out_pkg.sv
package ep_out_pkg;

  typedef logic [7:0] byte_t;

  // Round-robin successor of a bank index.
  function automatic int unsigned bank_after(input int unsigned idx,
                                             input int unsigned nbanks);
    if (idx + 1 >= nbanks) return 0;
    return idx + 1;
  endfunction

endpackage

// File: rtl/ep_out_rx_ctrl.sv
// USB-side packet intake: per-packet accept decision, write offset, bank pointer.
module ep_out_rx_ctrl
  import ep_out_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int DEPTH     = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 byte_vld,
  input  byte_t                byte_in,
  input  logic                 pkt_end,
  input  logic [NUM_BANKS-1:0] bank_full,
  output logic                 wr_en,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] wr_bank,
  output logic [$clog2(DEPTH)-1:0]   wr_addr,
  output byte_t                wr_data,
  output logic                 commit,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] commit_bank,
  output logic [$clog2(DEPTH+1)-1:0] commit_cnt,
  output logic                 hs_valid,
  output logic                 hs_nak
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              in_pkt_q, in_pkt_d;
  logic              acc_q, acc_d;
  logic [CNT_W-1:0]  off_q, off_d;
  logic [BANK_W-1:0] ptr_q, ptr_d;
  logic              hs_valid_q, hs_valid_d;
  logic              hs_nak_q, hs_nak_d;
  logic              beat, acc_now, room;

  always_comb begin
    beat     = byte_vld | pkt_end;
    acc_now  = in_pkt_q ? acc_q : (cfg_en & ~bank_full[ptr_q]);
    room     = (off_q < CNT_W'(DEPTH));
    wr_en    = byte_vld & acc_now & room;
    commit   = pkt_end & acc_now;
    commit_cnt = off_q + CNT_W'(wr_en);

    in_pkt_d = in_pkt_q;
    acc_d    = acc_q;
    off_d    = off_q;
    ptr_d    = ptr_q;
    if (beat && !in_pkt_q) acc_d = acc_now;
    if (pkt_end) begin
      in_pkt_d = 1'b0;
      off_d    = '0;
    end else if (byte_vld) begin
      in_pkt_d = 1'b1;
      if (wr_en) off_d = off_q + CNT_W'(1);
    end
    if (commit) ptr_d = BANK_W'(bank_after(32'(ptr_q), NUM_BANKS));
    hs_valid_d = pkt_end;
    hs_nak_d   = pkt_end & ~acc_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q   <= 1'b0;
      acc_q      <= 1'b0;
      off_q      <= '0;
      ptr_q      <= '0;
      hs_valid_q <= 1'b0;
      hs_nak_q   <= 1'b0;
    end else begin
      in_pkt_q   <= in_pkt_d;
      acc_q      <= acc_d;
      off_q      <= off_d;
      ptr_q      <= ptr_d;
      hs_valid_q <= hs_valid_d;
      hs_nak_q   <= hs_nak_d;
    end
  end

  assign wr_bank     = ptr_q;
  assign commit_bank = ptr_q;
  assign wr_addr     = off_q[ADDR_W-1:0];
  assign wr_data     = byte_in;
  assign hs_valid    = hs_valid_q;
  assign hs_nak      = hs_nak_q;

endmodule

// File: rtl/ep_out_bank_store.sv
// Packet storage: one flop array per bank, fall-through read.
module ep_out_bank_store
  import ep_out_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int DEPTH     = 64
) (
  input  logic clk,
  input  logic wr_en,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] wr_bank,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  byte_t wr_data,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] rd_bank,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output byte_t rd_data
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  byte_t rd_word [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    byte_t mem [DEPTH];
    logic  we;
    assign we = wr_en & (wr_bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (we) mem[wr_addr] <= wr_data;
    end
    assign rd_word[b] = mem[rd_addr];
  end

  assign rd_data = rd_word[rd_bank];

endmodule

// File: rtl/ep_out_bank_status.sv
// Per-bank ownership and byte count.
module ep_out_bank_status #(
  parameter int NUM_BANKS = 2,
  parameter int DEPTH     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] commit_bank,
  input  logic [$clog2(DEPTH+1)-1:0] commit_cnt,
  input  logic release_en,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] rel_bank,
  output logic [NUM_BANKS-1:0] full,
  output logic [$clog2(DEPTH+1)-1:0] cnt [NUM_BANKS]
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stat
    logic             full_q, full_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
      full_d = full_q;
      cnt_d  = cnt_q;
      if (commit && commit_bank == BANK_W'(b)) begin
        full_d = 1'b1;
        cnt_d  = commit_cnt;
      end else if (release_en && rel_bank == BANK_W'(b)) begin
        full_d = 1'b0;
        cnt_d  = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        full_q <= full_d;
        cnt_q  <= cnt_d;
      end
    end

    assign full[b] = full_q;
    assign cnt[b]  = cnt_q;
  end

endmodule

// File: rtl/ep_out_cpu_ctrl.sv
// CPU view: current bank, received flag, release, read offset.
module ep_out_cpu_ctrl
  import ep_out_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int DEPTH     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_BANKS-1:0] bank_full,
  input  logic commit,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] commit_bank,
  input  logic ack_rx,
  input  logic release_req,
  input  logic rd_en,
  input  logic [$clog2(DEPTH+1)-1:0] cur_cnt,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] cur_bank,
  output logic rx_flag,
  output logic bank_flag,
  output logic release_en,
  output logic [$clog2(DEPTH+1)-1:0] rd_off,
  output logic rd_valid
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [BANK_W-1:0] cur_q, cur_d, nb;
  logic              rx_q, rx_d;
  logic [CNT_W-1:0]  off_q, off_d;
  logic              owned, nb_full, commit_cur;

  always_comb begin
    owned      = bank_full[cur_q];
    release_en = release_req & owned;
    nb         = BANK_W'(bank_after(32'(cur_q), NUM_BANKS));
    nb_full    = (nb != cur_q) & (bank_full[nb] | (commit & (commit_bank == nb)));
    commit_cur = commit & (commit_bank == cur_q);
    rd_valid   = owned & (off_q < cur_cnt);

    cur_d = cur_q;
    rx_d  = rx_q;
    off_d = off_q;
    if (release_en) begin
      cur_d = nb;
      rx_d  = nb_full;
      off_d = '0;
    end else begin
      if (commit_cur)  rx_d = 1'b1;
      else if (ack_rx) rx_d = 1'b0;
      if (rd_en && rd_valid) off_d = off_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rx_q  <= 1'b0;
      off_q <= '0;
    end else begin
      cur_q <= cur_d;
      rx_q  <= rx_d;
      off_q <= off_d;
    end
  end

  assign cur_bank  = cur_q;
  assign rx_flag   = rx_q;
  assign bank_flag = owned;
  assign rd_off    = off_q;

endmodule

// File: rtl/ep_out_ctrl.sv
// Top: multi-bank OUT endpoint receive controller.
module ep_out_ctrl
  import ep_out_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int DEPTH     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic usb_byte_vld,
  input  logic [7:0] usb_byte,
  input  logic usb_pkt_end,
  output logic usb_hs_valid,
  output logic usb_hs_nak,
  input  logic cpu_rx_ie,
  input  logic cpu_ack_rx,
  input  logic cpu_release,
  input  logic cpu_rd_en,
  output logic [7:0] cpu_rd_data,
  output logic [$clog2(DEPTH+1)-1:0] cpu_byte_cnt,
  output logic cpu_rx_flag,
  output logic cpu_bank_flag,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] cpu_bank_sel,
  output logic irq
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic                 wr_en, commit, release_en, rd_valid, rx_flag;
  logic [BANK_W-1:0]    wr_bank, commit_bank, cur_bank;
  logic [ADDR_W-1:0]    wr_addr;
  byte_t                wr_data, store_rd;
  logic [CNT_W-1:0]     commit_cnt, rd_off, cur_cnt;
  logic [NUM_BANKS-1:0] full;
  logic [CNT_W-1:0]     cnt [NUM_BANKS];

  ep_out_rx_ctrl #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .byte_vld(usb_byte_vld), .byte_in(usb_byte), .pkt_end(usb_pkt_end),
    .bank_full(full),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_bank(commit_bank), .commit_cnt(commit_cnt),
    .hs_valid(usb_hs_valid), .hs_nak(usb_hs_nak)
  );

  ep_out_bank_store #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_bank(cur_bank), .rd_addr(rd_off[ADDR_W-1:0]),
    .rd_data(store_rd)
  );

  ep_out_bank_status #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_bank(commit_bank),
    .commit_cnt(commit_cnt), .release_en(release_en), .rel_bank(cur_bank),
    .full(full), .cnt(cnt)
  );

  ep_out_cpu_ctrl #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_cpu (
    .clk(clk), .rst_n(rst_n), .bank_full(full), .commit(commit),
    .commit_bank(commit_bank), .ack_rx(cpu_ack_rx), .release_req(cpu_release),
    .rd_en(cpu_rd_en), .cur_cnt(cur_cnt), .cur_bank(cur_bank),
    .rx_flag(rx_flag), .bank_flag(cpu_bank_flag), .release_en(release_en),
    .rd_off(rd_off), .rd_valid(rd_valid)
  );

  assign cur_cnt      = cnt[cur_bank];
  assign cpu_byte_cnt = cur_cnt;
  assign cpu_rd_data  = rd_valid ? store_rd : 8'h00;
  assign cpu_rx_flag  = rx_flag;
  assign cpu_bank_sel = cur_bank;
  assign irq          = rx_flag & cpu_rx_ie;

endmodule

// File: rtl/ep_out_ctrl_chk.sv
// Port-level temporal checks, attached to every ep_out_ctrl instance.
module ep_out_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int DEPTH     = 64
) (
  input logic clk,
  input logic rst_n,
  input logic usb_pkt_end,
  input logic usb_hs_valid,
  input logic cpu_rx_ie,
  input logic cpu_ack_rx,
  input logic cpu_release,
  input logic [7:0] cpu_rd_data,
  input logic [$clog2(DEPTH+1)-1:0] cpu_byte_cnt,
  input logic cpu_rx_flag,
  input logic cpu_bank_flag,
  input logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] cpu_bank_sel,
  input logic irq
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  function automatic logic [BANK_W-1:0] succ(input logic [BANK_W-1:0] s);
    if (32'(s) + 1 >= NUM_BANKS) return '0;
    return s + BANK_W'(1);
  endfunction

  assert_hs_follows_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    usb_pkt_end |=> usb_hs_valid);

  assert_hs_needs_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    usb_hs_valid |-> $past(usb_pkt_end));

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cpu_rx_ie && cpu_rx_flag));

  assert_ack_keeps_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_rx && !cpu_release && cpu_bank_flag) |=> (!cpu_rx_flag && cpu_bank_flag));

  assert_release_rotates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_release && cpu_bank_flag) |=> (cpu_bank_sel == succ($past(cpu_bank_sel))));

  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_byte_cnt <= CNT_W'(DEPTH));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_bank_flag |-> (cpu_rd_data == 8'h00 && cpu_byte_cnt == '0));

  assert_empty_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_release && !cpu_bank_flag) |=> $stable(cpu_bank_sel));

endmodule

bind ep_out_ctrl ep_out_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .usb_pkt_end(usb_pkt_end), .usb_hs_valid(usb_hs_valid),
  .cpu_rx_ie(cpu_rx_ie), .cpu_ack_rx(cpu_ack_rx), .cpu_release(cpu_release),
  .cpu_rd_data(cpu_rd_data), .cpu_byte_cnt(cpu_byte_cnt), .cpu_rx_flag(cpu_rx_flag),
  .cpu_bank_flag(cpu_bank_flag), .cpu_bank_sel(cpu_bank_sel), .irq(irq)
);

// File: tb/tb_ep_out_ctrl.sv
`timescale 1ns/1ps
module tb_ep_out_ctrl;
  localparam int NB = 2;
  localparam int DP = 4;
  localparam int CW = $clog2(DP + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en, usb_byte_vld, usb_pkt_end;
  logic [7:0] usb_byte;
  logic usb_hs_valid, usb_hs_nak;
  logic cpu_rx_ie, cpu_ack_rx, cpu_release, cpu_rd_en;
  logic [7:0] cpu_rd_data;
  logic [CW-1:0] cpu_byte_cnt;
  logic cpu_rx_flag, cpu_bank_flag, irq;
  logic [0:0] cpu_bank_sel;

  always #2 clk = ~clk;

  ep_out_ctrl #(.NUM_BANKS(NB), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .usb_byte_vld(usb_byte_vld), .usb_byte(usb_byte), .usb_pkt_end(usb_pkt_end),
    .usb_hs_valid(usb_hs_valid), .usb_hs_nak(usb_hs_nak),
    .cpu_rx_ie(cpu_rx_ie), .cpu_ack_rx(cpu_ack_rx), .cpu_release(cpu_release),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_byte_cnt(cpu_byte_cnt),
    .cpu_rx_flag(cpu_rx_flag), .cpu_bank_flag(cpu_bank_flag),
    .cpu_bank_sel(cpu_bank_sel), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  // Bench model of the endpoint
  bit m_full [NB];
  int m_len  [NB];
  int m_id   [NB];
  int m_cur = 0;
  int m_wr  = 0;
  bit m_rx  = 0;
  bit m_ie  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int id, input int i);
    return 8'((id * 37 + i * 5 + 3) & 255);
  endfunction

  task automatic view(input string req);
    chk({req, " bank flag"}, int'(cpu_bank_flag), int'(m_full[m_cur]));
    chk({req, " rx flag"},   int'(cpu_rx_flag),   int'(m_rx));
    chk({req, " bank sel"},  int'(cpu_bank_sel),  m_cur);
    chk({req, " count"},     int'(cpu_byte_cnt),  m_full[m_cur] ? m_len[m_cur] : 0);
    chk({req, " irq"},       int'(irq),           int'(m_rx && m_ie));
  endtask

  task automatic send(input int n, input int id, input string req);
    bit acc;
    acc = cfg_en && !m_full[m_wr];
    if (n == 0) begin
      usb_pkt_end = 1'b1;
      @(negedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        usb_byte_vld = 1'b1;
        usb_byte     = pat(id, i);
        usb_pkt_end  = (i == n - 1);
        @(negedge clk);
      end
    end
    usb_byte_vld = 1'b0;
    usb_pkt_end  = 1'b0;
    if (acc) begin
      m_full[m_wr] = 1'b1;
      m_len[m_wr]  = (n > DP) ? DP : n;
      m_id[m_wr]   = id;
      if (m_wr == m_cur) m_rx = 1'b1;
      m_wr = (m_wr + 1) % NB;
    end
    chk({req, " hs valid"}, int'(usb_hs_valid), 1);
    chk({req, " hs nak"},   int'(usb_hs_nak),   int'(!acc));
    view(req);
  endtask

  task automatic read_all(input string req);
    int n;
    n = m_full[m_cur] ? m_len[m_cur] : 0;
    for (int i = 0; i < n; i++) begin
      chk({req, " data"}, int'(cpu_rd_data), int'(pat(m_id[m_cur], i)));
      cpu_rd_en = 1'b1;
      @(negedge clk);
      cpu_rd_en = 1'b0;
    end
    chk({req, " data past count"}, int'(cpu_rd_data), 0);
  endtask

  task automatic rel(input string req);
    cpu_release = 1'b1;
    @(negedge clk);
    cpu_release = 1'b0;
    if (m_full[m_cur]) begin
      m_full[m_cur] = 1'b0;
      m_cur = (m_cur + 1) % NB;
      m_rx  = m_full[m_cur];
    end
    view(req);
  endtask

  task automatic ack(input string req);
    cpu_ack_rx = 1'b1;
    @(negedge clk);
    cpu_ack_rx = 1'b0;
    m_rx = 1'b0;
    view(req);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    cfg_en = 1'b0; usb_byte_vld = 1'b0; usb_byte = 8'h00; usb_pkt_end = 1'b0;
    cpu_rx_ie = 1'b0; cpu_ack_rx = 1'b0; cpu_release = 1'b0; cpu_rd_en = 1'b0;
    for (int b = 0; b < NB; b++) begin m_full[b] = 0; m_len[b] = 0; m_id[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    view("R1 reset");
    chk("R1 reset hs valid", int'(usb_hs_valid), 0);

    // R2: disabled endpoint refuses
    send(3, 1, "R2 disabled");
    cfg_en = 1'b1;
    cpu_rx_ie = 1'b1; m_ie = 1'b1;

    // Length sweep: R12 (0), R3 (1..DP), R9 (> DP); banks alternate each pass
    for (int len = 0; len <= DP + 2; len++) begin
      send(len, 10 + len, (len == 0) ? "R12 zero length" : (len > DP) ? "R9 overflow" : "R3 accept");
      cpu_rx_ie = 1'b0; m_ie = 1'b0;
      #1 chk("R4 irq masked", int'(irq), 0);
      cpu_rx_ie = 1'b1; m_ie = 1'b1;
      #1 chk("R4 irq enabled", int'(irq), int'(m_rx));
      @(negedge clk);
      ack("R5 ack");
      read_all("R10 read after ack");
      rel("R6 release");
      rel("R11 empty release");
    end

    // R7/R8: back-to-back fill of both banks, then full
    send(3, 50, "R7 first");
    ack("R7 ack first");
    send(2, 51, "R7 second into other bank");
    send(4, 52, "R8 all full");
    read_all("R8 first intact");
    rel("R6 reload from held bank");
    read_all("R8 second intact");
    rel("R6 release to empty");

    // R13: release in the middle of a refused packet
    send(1, 60, "R13 fill a");
    send(1, 61, "R13 fill b");
    usb_byte_vld = 1'b1; usb_byte = pat(62, 0);
    @(negedge clk);
    usb_byte = pat(62, 1); cpu_release = 1'b1;
    @(negedge clk);
    cpu_release = 1'b0;
    m_full[m_cur] = 1'b0; m_cur = (m_cur + 1) % NB; m_rx = m_full[m_cur];
    usb_byte = pat(62, 2); usb_pkt_end = 1'b1;
    @(negedge clk);
    usb_byte_vld = 1'b0; usb_pkt_end = 1'b0;
    chk("R13 hs valid", int'(usb_hs_valid), 1);
    chk("R13 refused at first beat", int'(usb_hs_nak), 1);
    view("R13 after refused");
    send(2, 63, "R13 next accepted");
    read_all("R13 drain b");
    rel("R13 release b");
    read_all("R7 round robin data");
    rel("R13 release last");

    summary();
  end

endmodule